// File: doc/BRIEF.md
# Package Sleep State Coordinator

This block turns the sleep states reported by a set of cores into one package-level low-power state and steps the package between those states. Each cycle it finds the shallowest core state, decides whether the package may leave its current state, and registers the result. Shallow package states (PC0, C1E) follow the cores directly. Deep states (PC3, PC6) are coordinated: they need every core at C3 or deeper and a platform permission input, and the package must pass through PC2 on the way in from a shallow state.

Break events arrive on a single valid-qualified channel. Each one either targets a core or is a memory or snoop access. A core event sends a one-cycle wake strobe to the target core. An unmasked core event forces the package to PC0. A masked core event leaves the package in its prior state. A memory event keeps the prior state, unless the platform asks for the shallower state while the access is serviced.

Top module: `pkg_sleep_coord`

## Requirements
- R1: While rst_ni is low, and after reset, the package state reads PC0 and no wake strobe is set while no break event is offered. Package codes: 0=PC0, 1=C1E, 2=PC2, 3=PC3, 4=PC6.
- R2: The resolved target is the shallowest core state. Core codes (2 bits per core, core k in bits 2k+1:2k) are 0=C0, 1=C1, 2=C3, 3=C6. Any core in C0 gives PC0. Otherwise any core in C3 with none shallower gives PC3. PC6 is the target only when every core is in C6.
- R3: When no core is in C0 and at least one core is in C1, the package state becomes C1E.
- R4: exec_allowed_o is 0 exactly when every core reports C3 or C6. coord_req_o is 1 when exec_allowed_o is 0 and the registered package state differs from the resolved target.
- R5: From PC0 or C1E, a deep target moves the package to PC2. The package never goes from PC0 or C1E straight to PC3 or PC6.
- R6: In PC2, with plat_deep_ok_i low and no break event, the package stays in PC2. With plat_deep_ok_i high it goes to the deep target on the next edge.
- R7: The package moves from one sleep state to another without passing through PC0: PC3 and PC6 change into each other directly, and a deep state falls to C1E directly.
- R8: A core break event (brk_valid_i=1, brk_mem_i=0) raises wake_o[brk_core_i] in the same cycle and no other wake bit. When unmasked (brk_masked_i=0), the package state is PC0 after the next edge.
- R9: A masked core break event (brk_masked_i=1) leaves the package state unchanged across the edge, while still strobing the target core's wake bit.
- R10: A memory or snoop break event (brk_mem_i=1) raises no wake bit. It leaves the package state unchanged when plat_hold_i=0, and sets it to PC0 when plat_hold_i=1.
- R11: pkg_state_o is registered: it shows the effect of the inputs one clock edge after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_state_i | input | 2*N_CORES | Per-core sleep state codes |
| plat_deep_ok_i | input | 1 | Platform permits deep coordinated states |
| plat_hold_i | input | 1 | Platform wants the shallower state during a memory event |
| brk_valid_i | input | 1 | Break event present this cycle |
| brk_core_i | input | CORE_W | Target core of a core break event |
| brk_masked_i | input | 1 | Core break event is masked |
| brk_mem_i | input | 1 | Break event is a memory or snoop access |
| pkg_state_o | output | 3 | Registered package state code |
| exec_allowed_o | output | 1 | Low when all cores are at C3 or deeper |
| coord_req_o | output | 1 | Request to enter a coordinated package state |
| wake_o | output | N_CORES | One-cycle per-core wake strobes |

## Verification
Several properties are checked on every cycle: the wake strobes are one-hot or zero, the package never jumps from a shallow state into PC3 or PC6, PC2 holds while permission is low, and each break event kind leads to its required state on the next edge. The resolution order, the C1E promotion, the direct moves between sleep states and the exact values of exec_allowed_o and coord_req_o against the core codes can only be shown by the bench's scenarios. Reset behaviour is also covered by those scenarios.

// File: rtl/pkg_sleep_pkg.sv
package pkg_sleep_pkg;
  typedef enum logic [1:0] {
    CS_C0 = 2'd0,
    CS_C1 = 2'd1,
    CS_C3 = 2'd2,
    CS_C6 = 2'd3
  } core_st_e;

  typedef enum logic [2:0] {
    PS_PC0 = 3'd0,
    PS_C1E = 3'd1,
    PS_PC2 = 3'd2,
    PS_PC3 = 3'd3,
    PS_PC6 = 3'd4
  } pkg_st_e;
endpackage

// File: rtl/pkg_core_resolver.sv
module pkg_core_resolver
  import pkg_sleep_pkg::*;
#(
  parameter int N_CORES = 2
) (
  input  logic [2*N_CORES-1:0] core_state_i,
  output pkg_st_e              target_o,
  output logic                 exec_allowed_o
);
  logic [N_CORES-1:0] is_c0, is_c1, is_c6, is_deep;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    logic [1:0] st;
    assign st         = core_state_i[2*i +: 2];
    assign is_c0[i]   = (st == CS_C0);
    assign is_c1[i]   = (st == CS_C1);
    assign is_c6[i]   = (st == CS_C6);
    assign is_deep[i] = (st == CS_C3) || (st == CS_C6);
  end

  always_comb begin
    if (|is_c0)       target_o = PS_PC0;
    else if (|is_c1)  target_o = PS_C1E;
    else if (&is_c6)  target_o = PS_PC6;
    else              target_o = PS_PC3;
  end

  assign exec_allowed_o = ~(&is_deep);

  always_comb begin
    p_pc6_needs_deep_r2: assert (!(target_o == PS_PC6) || !exec_allowed_o);
  end
endmodule

// File: rtl/pkg_break_decoder.sv
module pkg_break_decoder #(
  parameter int N_CORES = 2,
  parameter int CORE_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               brk_valid_i,
  input  logic [CORE_W-1:0]  brk_core_i,
  input  logic               brk_masked_i,
  input  logic               brk_mem_i,
  input  logic               plat_hold_i,
  output logic               force_pc0_o,
  output logic               keep_prior_o,
  output logic [N_CORES-1:0] wake_o
);
  logic core_evt;
  assign core_evt = brk_valid_i && !brk_mem_i;

  for (genvar i = 0; i < N_CORES; i++) begin : g_wake
    assign wake_o[i] = core_evt && (brk_core_i == CORE_W'(i));
  end

  // memory events wake the package only on platform request
  assign force_pc0_o  = brk_valid_i && (brk_mem_i ? plat_hold_i : !brk_masked_i);
  assign keep_prior_o = brk_valid_i && !force_pc0_o;

  always_comb begin
    p_wake_onehot_r8: assert ($onehot0(wake_o));
    p_mem_no_wake_r10: assert (!(brk_valid_i && brk_mem_i) || (wake_o == '0));
  end
endmodule

// File: rtl/pkg_sleep_coord.sv
module pkg_sleep_coord
  import pkg_sleep_pkg::*;
#(
  parameter int N_CORES = 2,
  parameter int CORE_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*N_CORES-1:0] core_state_i,
  input  logic                 plat_deep_ok_i,
  input  logic                 plat_hold_i,
  input  logic                 brk_valid_i,
  input  logic [CORE_W-1:0]    brk_core_i,
  input  logic                 brk_masked_i,
  input  logic                 brk_mem_i,
  output logic [2:0]           pkg_state_o,
  output logic                 exec_allowed_o,
  output logic                 coord_req_o,
  output logic [N_CORES-1:0]   wake_o
);
  pkg_st_e target, pkg_q, pkg_d;
  logic    ea, force_pc0, keep_prior;

  pkg_core_resolver #(.N_CORES(N_CORES)) u_res (
    .core_state_i  (core_state_i),
    .target_o      (target),
    .exec_allowed_o(ea)
  );

  pkg_break_decoder #(.N_CORES(N_CORES), .CORE_W(CORE_W)) u_brk (
    .brk_valid_i (brk_valid_i),
    .brk_core_i  (brk_core_i),
    .brk_masked_i(brk_masked_i),
    .brk_mem_i   (brk_mem_i),
    .plat_hold_i (plat_hold_i),
    .force_pc0_o (force_pc0),
    .keep_prior_o(keep_prior),
    .wake_o      (wake_o)
  );

  always_comb begin
    pkg_d = pkg_q;
    if (force_pc0) begin
      pkg_d = PS_PC0;
    end else if (keep_prior) begin
      pkg_d = pkg_q;
    end else if (!ea) begin
      // deep target: shallow states go to PC2 first, permission gates the rest
      if (pkg_q == PS_PC0 || pkg_q == PS_C1E) pkg_d = PS_PC2;
      else if (plat_deep_ok_i)                pkg_d = target;
      else                                    pkg_d = PS_PC2;
    end else begin
      pkg_d = target;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pkg_q <= PS_PC0;
    else         pkg_q <= pkg_d;
  end

  assign pkg_state_o    = pkg_q;
  assign exec_allowed_o = ea;
  assign coord_req_o    = !ea && (pkg_q != target);

  p_no_direct_deep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkg_q == PS_PC0 || pkg_q == PS_C1E) |=> !(pkg_q == PS_PC3 || pkg_q == PS_PC6));

  p_pc2_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkg_q == PS_PC2 && !plat_deep_ok_i && !brk_valid_i && !ea) |=> (pkg_q == PS_PC2));

  p_unmasked_wake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_valid_i && !brk_mem_i && !brk_masked_i) |=> (pkg_q == PS_PC0));

  p_masked_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_valid_i && !brk_mem_i && brk_masked_i) |=> $stable(pkg_q));

  p_mem_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_valid_i && brk_mem_i && !plat_hold_i) |=> $stable(pkg_q));

  p_state_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkg_q inside {PS_PC0, PS_C1E, PS_PC2, PS_PC3, PS_PC6});
endmodule

// File: tb/pkg_sleep_coord_tb.sv
module pkg_sleep_coord_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_CORES    = 2;
  localparam int NVEC       = 21;

  typedef struct packed {
    logic [3:0] cores;
    logic       ok;
    logic       bv;
    logic       bcore;
    logic       msk;
    logic       mem;
    logic       hold;
    logic [2:0] pkg;
    logic       ea;
    logic       req;
    logic [1:0] wake;
  } vec_t;

  // cores {core1,core0}; ctrl {ok,bv,bcore,msk,mem,hold}; {ea,req}
  localparam vec_t TBL [NVEC] = '{
    vec_t'({4'b0000, 6'b100000, 3'd0, 2'b10, 2'b00}), // R2 all C0
    vec_t'({4'b0100, 6'b100000, 3'd0, 2'b10, 2'b00}), // R2 one C0
    vec_t'({4'b0101, 6'b100000, 3'd1, 2'b10, 2'b00}), // R3 C1E
    vec_t'({4'b1001, 6'b100000, 3'd1, 2'b10, 2'b00}), // R3 C1 + C3
    vec_t'({4'b1010, 6'b000000, 3'd2, 2'b01, 2'b00}), // R5 C1E->PC2
    vec_t'({4'b1010, 6'b000000, 3'd2, 2'b01, 2'b00}), // R6 hold PC2
    vec_t'({4'b1010, 6'b100000, 3'd3, 2'b01, 2'b00}), // R6 PC2->PC3
    vec_t'({4'b1111, 6'b100000, 3'd4, 2'b01, 2'b00}), // R7 PC3->PC6
    vec_t'({4'b1110, 6'b100000, 3'd3, 2'b01, 2'b00}), // R7 PC6->PC3
    vec_t'({4'b0111, 6'b100000, 3'd1, 2'b10, 2'b00}), // R7 PC3->C1E
    vec_t'({4'b1111, 6'b100000, 3'd2, 2'b01, 2'b00}), // R5
    vec_t'({4'b1111, 6'b100000, 3'd4, 2'b01, 2'b00}), // R2 PC6
    vec_t'({4'b1111, 6'b110010, 3'd4, 2'b00, 2'b00}), // R10 no hold
    vec_t'({4'b1111, 6'b110011, 3'd0, 2'b00, 2'b00}), // R10 hold
    vec_t'({4'b1111, 6'b100000, 3'd2, 2'b01, 2'b00}), // R5 PC0->PC2
    vec_t'({4'b1111, 6'b100000, 3'd4, 2'b01, 2'b00}), // R6
    vec_t'({4'b1111, 6'b111100, 3'd4, 2'b00, 2'b10}), // R9 masked
    vec_t'({4'b1111, 6'b111000, 3'd0, 2'b00, 2'b10}), // R8 unmasked
    vec_t'({4'b0011, 6'b100000, 3'd0, 2'b10, 2'b00}), // R4 ea back high
    vec_t'({4'b1111, 6'b000000, 3'd2, 2'b01, 2'b00}), // R6
    vec_t'({4'b1111, 6'b010000, 3'd0, 2'b01, 2'b01})  // R8 from PC2
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [2*N_CORES-1:0] core_state = '0;
  logic                 deep_ok = 1'b0, hold = 1'b0;
  logic                 bv = 1'b0, bcore = 1'b0, msk = 1'b0, mem = 1'b0;
  logic [2:0]           pkg_state;
  logic                 ea, req;
  logic [N_CORES-1:0]   wake;
  int                   n_run = 0, n_fail = 0;
  bit                   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkg_sleep_coord #(.N_CORES(N_CORES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .core_state_i(core_state),
    .plat_deep_ok_i(deep_ok), .plat_hold_i(hold), .brk_valid_i(bv),
    .brk_core_i(bcore), .brk_masked_i(msk), .brk_mem_i(mem),
    .pkg_state_o(pkg_state), .exec_allowed_o(ea), .coord_req_o(req),
    .wake_o(wake)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD*2 + 1);
    check("R1 pkg in reset", 8'(pkg_state), 8'd0);
    check("R1 wake in reset", 8'(wake), 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pkg after reset", 8'(pkg_state), 8'd0);

    for (int k = 0; k < NVEC; k++) begin
      core_state = TBL[k].cores;
      deep_ok = TBL[k].ok;  bv = TBL[k].bv;  bcore = TBL[k].bcore;
      msk = TBL[k].msk;     mem = TBL[k].mem; hold = TBL[k].hold;
      #1;
      check($sformatf("R4 ea vec %0d", k), 8'(ea), 8'(TBL[k].ea));
      check($sformatf("R4 req vec %0d", k), 8'(req), 8'(TBL[k].req));
      check($sformatf("R8 R10 wake vec %0d", k), 8'(wake), 8'(TBL[k].wake));
      check($sformatf("R11 pre-edge vec %0d", k), 8'(pkg_state),
            8'(k == 0 ? 3'd0 : TBL[k-1].pkg));
      @(negedge clk);
      check($sformatf("R2 pkg vec %0d", k), 8'(pkg_state), 8'(TBL[k].pkg));
    end

    // R1 asynchronous reset from a deep state
    bv = 1'b0; deep_ok = 1'b1; core_state = 4'b1111;
    @(negedge clk); @(negedge clk);
    check("R6 reached PC6", 8'(pkg_state), 8'd4);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 8'(pkg_state), 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 masked event in PC2 keeps PC2, strobes core 0
    deep_ok = 1'b0;
    @(negedge clk);
    check("R5 PC2 after reset", 8'(pkg_state), 8'd2);
    bv = 1'b1; bcore = 1'b0; msk = 1'b1; mem = 1'b0;
    #1;
    check("R9 wake core0", 8'(wake), 8'd1);
    @(negedge clk);
    check("R9 PC2 kept", 8'(pkg_state), 8'd2);
    bv = 1'b0; msk = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule